// File: doc/BRIEF.md
# Gate Driver Protection Logic

This block is the digital control core of a single-channel gate driver for IGBTs and power MOSFETs. It takes a drive command from an optical receiver, a pin that sets the polarity of that command, a pin that selects how faults are handled, a flag from an external desaturation comparator and a flag from an external supply monitor. It produces a registered gate-on command for the output stage and a status sink signal. When the status sink is 1, the status transistor conducts and the return fiber goes dark.

After the gate turns on, the desaturation flag is ignored for a settling window. After that window, a high flag counts as an overcurrent. In normal mode an overcurrent forces the gate off at once and locks it off for a blocking period, and the drive input has no effect during that period. In series mode the gate is left alone and the fault is only reported, so that a central controller can switch off all devices in a chain together.

The status line carries two things. Every edge of the raw drive input gets a short acknowledge pulse, which lets the controller confirm that both fibers work. Every fault gets a long pulse that lasts the whole blocking period. Every timing value is a parameter counted in clock cycles.

Top module: `gate_guard`

## Requirements
- R1: The drive demand is `drv_in XNOR pol_inv`. With `pol_inv`=0 a low drive input requests the gate on. With `pol_inv`=1 a high drive input requests it. A change of `pol_inv` alone moves the gate one cycle later and produces no acknowledge pulse.
- R2: While `rst` is high, `gate_on` is 0 and `status_sink` is 1.
- R3: Without a fault and with the supply good, `gate_on` follows the demand. A change of `drv_in` sampled at clock edge k shows on `gate_on` at edge k+1.
- R4: The desaturation flag has no effect until the gate has been on for RESP_CYC+1 consecutive cycles. The earliest forced turn-off comes at the (RESP_CYC+1)-th edge after `gate_on` rose.
- R5: In normal mode (`series_mode`=0), a desaturation fault drives `gate_on` to 0 at the edge where it is detected. `gate_on` stays 0 and `status_sink` stays 1 for exactly BLOCK_CYC cycles.
- R6: Drive input changes during the blocking period do not move the gate. The gate follows the demand again at the first edge after the period.
- R7: In series mode, a desaturation fault leaves `gate_on` following the demand. `status_sink` is 1 for the same BLOCK_CYC cycles as in R5.
- R8: At every edge that samples `supply_ok`=0, `status_sink` becomes 1. In normal mode `gate_on` also becomes 0. In series mode `gate_on` keeps following the demand.
- R9: Each rising or falling edge of `drv_in` makes `status_sink` 1 for ACK_CYC cycles, starting at the same edge where the gate reacts.
- R10: An input edge that arrives during an acknowledge pulse restarts the pulse. The line then stays 1 until ACK_CYC cycles after the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_in | input | 1 | Drive command from the optical receiver |
| pol_inv | input | 1 | Polarity select: 1 makes a high drive input mean on |
| series_mode | input | 1 | 1: faults are reported only; 0: faults force the gate off |
| desat_flag | input | 1 | Comparator output: measured collector voltage above reference |
| supply_ok | input | 1 | Supply monitor output, hysteresis applied outside the block |
| gate_on | output | 1 | Registered gate-on command |
| status_sink | output | 1 | Registered status sink; 1 means conducting (light off) |

## Verification
The assertions check the following on every cycle:
- no trip is started inside the settling window;
- the gate stays off while a normal-mode blocking count is running;
- series mode never drops a demanded gate;
- a low supply always forces the status line, and in normal mode the gate off;
- every input edge reloads the acknowledge timer and raises the status line.

Only the bench's scenarios can show the exact cycle counts. These are:
- the BLOCK_CYC length of the fault window;
- the release on the first edge after it;
- the ACK_CYC pulse length, and its restart;
- the one-cycle response to a polarity change.

// File: rtl/gg_pkg.sv
package gg_pkg;
  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gg_input_stage.sv
module gg_input_stage (
  input  logic clk,
  input  logic rst,
  input  logic drv_in,
  input  logic pol_inv,
  output logic demand,
  output logic edge_seen
);
  logic in_q;
  logic in_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= 1'b0;
      in_prev <= 1'b0;
    end else begin
      in_q    <= drv_in;
      in_prev <= in_q;
    end
  end

  // Polarity: pol_inv=0 -> low input requests on; pol_inv=1 -> high input requests on.
  assign demand    = in_q ~^ pol_inv;
  // Raw input edges are acknowledged regardless of polarity.
  assign edge_seen = in_q ^ in_prev;
endmodule

// File: rtl/gg_ack_timer.sv
module gg_ack_timer #(
  parameter int ACK_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  output logic ack_busy_nx
);
  localparam int AW = gg_pkg::cnt_w(ACK_CYC);

  logic [AW-1:0] ack_cnt;
  logic [AW-1:0] ack_nx;

  always_comb begin
    if (edge_seen)            ack_nx = AW'(ACK_CYC);
    else if (ack_cnt != '0)   ack_nx = ack_cnt - AW'(1);
    else                      ack_nx = '0;
    ack_busy_nx = (ack_nx != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) ack_cnt <= '0;
    else     ack_cnt <= ack_nx;
  end

  // R10: each edge reloads the full pulse length, even mid-pulse.
  a_r10_restart_full: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (ack_cnt == AW'(ACK_CYC)));
endmodule

// File: rtl/gg_fault_ctrl.sv
module gg_fault_ctrl #(
  parameter int RESP_CYC  = 6,
  parameter int BLOCK_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic demand,
  input  logic desat_flag,
  input  logic supply_ok,
  input  logic series_mode,
  output logic gate_q,
  output logic blk_busy_nx
);
  localparam int RW = gg_pkg::cnt_w(RESP_CYC);
  localparam int BW = gg_pkg::cnt_w(BLOCK_CYC);

  logic [RW-1:0] on_cnt;
  logic [BW-1:0] blk_cnt;
  logic [BW-1:0] blk_nx;
  logic          armed;
  logic          trip;
  logic          gate_nx;

  always_comb begin
    armed = gate_q && (on_cnt == RW'(RESP_CYC));
    trip  = armed && desat_flag && (blk_cnt == '0);
    if (trip)                blk_nx = BW'(BLOCK_CYC);
    else if (blk_cnt != '0)  blk_nx = blk_cnt - BW'(1);
    else                     blk_nx = '0;
    blk_busy_nx = (blk_nx != '0);
    gate_nx = demand && (series_mode || (!blk_busy_nx && supply_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      on_cnt  <= '0;
      blk_cnt <= '0;
    end else begin
      gate_q  <= gate_nx;
      blk_cnt <= blk_nx;
      if (!gate_q)                        on_cnt <= '0;
      else if (on_cnt != RW'(RESP_CYC))   on_cnt <= on_cnt + RW'(1);
    end
  end

  // R4: inside the settling window no blocking period can start.
  a_r4_no_early_trip: assert property (@(posedge clk) disable iff (rst)
    (gate_q && on_cnt != RW'(RESP_CYC) && blk_cnt == '0) |=> (blk_cnt == '0));

  // R5/R6: a running block set up in normal mode holds the gate off.
  a_r5_block_holds_off: assert property (@(posedge clk) disable iff (rst)
    ($past(!series_mode) && blk_cnt != '0) |-> !gate_q);

  // R7: series mode never drops a demanded gate.
  a_r7_series_keeps_gate: assert property (@(posedge clk) disable iff (rst)
    (series_mode && demand) |=> gate_q);
endmodule

// File: rtl/gate_guard.sv
module gate_guard #(
  parameter int RESP_CYC  = 6,
  parameter int BLOCK_CYC = 20,
  parameter int ACK_CYC   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic drv_in,
  input  logic pol_inv,
  input  logic series_mode,
  input  logic desat_flag,
  input  logic supply_ok,
  output logic gate_on,
  output logic status_sink
);
  logic demand;
  logic edge_seen;
  logic blk_busy_nx;
  logic ack_busy_nx;
  logic gate_q;
  logic status_q;

  gg_input_stage u_in (
    .clk       (clk),
    .rst       (rst),
    .drv_in    (drv_in),
    .pol_inv   (pol_inv),
    .demand    (demand),
    .edge_seen (edge_seen)
  );

  gg_fault_ctrl #(.RESP_CYC(RESP_CYC), .BLOCK_CYC(BLOCK_CYC)) u_flt (
    .clk         (clk),
    .rst         (rst),
    .demand      (demand),
    .desat_flag  (desat_flag),
    .supply_ok   (supply_ok),
    .series_mode (series_mode),
    .gate_q      (gate_q),
    .blk_busy_nx (blk_busy_nx)
  );

  gg_ack_timer #(.ACK_CYC(ACK_CYC)) u_ack (
    .clk         (clk),
    .rst         (rst),
    .edge_seen   (edge_seen),
    .ack_busy_nx (ack_busy_nx)
  );

  // Status sink merges supply alarm, fault window and edge acknowledge.
  always_ff @(posedge clk) begin
    if (rst) status_q <= 1'b1;
    else     status_q <= !supply_ok || blk_busy_nx || ack_busy_nx;
  end

  assign gate_on     = gate_q;
  assign status_sink = status_q;

  // R8: a low supply sample always darkens the status fiber.
  a_r8_low_supply_status: assert property (@(posedge clk) disable iff (rst)
    $past(!supply_ok) |-> status_q);

  // R8: in normal mode a low supply sample turns the gate off.
  a_r8_low_supply_gate: assert property (@(posedge clk) disable iff (rst)
    $past(!supply_ok && !series_mode) |-> !gate_q);

  // R9: every raw input edge is acknowledged on the next edge.
  a_r9_edge_acked: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> status_q);
endmodule

// File: tb/gate_guard_test.sv
`timescale 1ns/1ps
module gate_guard_test;
  localparam int RESP  = 6;
  localparam int BLOCK = 20;
  localparam int ACK   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_in = 1'b0;
  logic pol_inv = 1'b1;
  logic series_mode = 1'b0;
  logic desat_flag = 1'b0;
  logic supply_ok = 1'b1;
  logic gate_on;
  logic status_sink;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int    q_cyc[$];
  bit    q_g[$];
  bit    q_s[$];
  string q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gate_guard #(.RESP_CYC(RESP), .BLOCK_CYC(BLOCK), .ACK_CYC(ACK)) uut (
    .clk(clk), .rst(rst), .drv_in(drv_in), .pol_inv(pol_inv),
    .series_mode(series_mode), .desat_flag(desat_flag), .supply_ok(supply_ok),
    .gate_on(gate_on), .status_sink(status_sink)
  );

  task automatic compare(input bit g, input bit s, input string tag);
    n_chk++;
    if (gate_on !== g || status_sink !== s) begin
      n_bad++;
      $display("FAIL %s cycle %0d: gate=%b status=%b expected gate=%b status=%b",
               tag, cyc, gate_on, status_sink, g, s);
    end
  endtask

  // Monitor: pops expected items due in this cycle.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] == cyc) compare(q_g[0], q_s[0], q_tag[0]);
      else begin
        n_chk++; n_bad++;
        $display("FAIL %s: missed slot %0d (now %0d) expected gate=%b status=%b",
                 q_tag[0], q_cyc[0], cyc, q_g[0], q_s[0]);
      end
      void'(q_cyc.pop_front()); void'(q_g.pop_front());
      void'(q_s.pop_front());   void'(q_tag.pop_front());
    end
  end

  task automatic exp_at(input int at, input bit g, input bit s, input string tag);
    q_cyc.push_back(at); q_g.push_back(g); q_s.push_back(s); q_tag.push_back(tag);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (q_cyc.size() > 0) @(negedge clk);
    step();
  endtask

  // Drive an edge now; gate settles to g two edges later with an ACK pulse.
  task automatic edge_to(input bit v, input bit g, input string tag);
    int c;
    step();
    c = cyc;
    drv_in = v;
    exp_at(c + 1, !g, 1'b0, tag);
    exp_at(c + 2, g, 1'b1, tag);
    exp_at(c + 1 + ACK, g, 1'b1, tag);
    exp_at(c + 2 + ACK, g, 1'b0, tag);
    drain();
  endtask

  initial begin
    int c;
    int f;
    // R2: reset state.
    repeat (3) step();
    compare(1'b0, 1'b1, "R2 reset");
    c = cyc;
    rst = 1'b0;
    exp_at(c + 1, 1'b0, 1'b0, "R2 idle after reset");
    drain();

    // R1/R3/R9: pol_inv=1, high input turns on, low turns off.
    edge_to(1'b1, 1'b1, "R1 R3 R9 turn-on");
    edge_to(1'b0, 1'b0, "R1 R3 R9 turn-off");

    // R10: second edge during the pulse restarts it.
    step(); c = cyc; drv_in = 1'b1;
    exp_at(c + 2, 1'b1, 1'b1, "R10 first pulse");
    exp_at(c + 3, 1'b1, 1'b1, "R10 first pulse");
    exp_at(c + 4, 1'b0, 1'b1, "R10 restarted");
    exp_at(c + 6, 1'b0, 1'b1, "R10 restarted");
    exp_at(c + 7, 1'b0, 1'b1, "R10 restarted");
    exp_at(c + 8, 1'b0, 1'b0, "R10 pulse end");
    wait_cyc(c + 2); drv_in = 1'b0;
    drain();

    // R4/R5/R6: normal mode desaturation fault.
    step(); c = cyc; drv_in = 1'b1; desat_flag = 1'b1;
    f = c + RESP + 3;
    exp_at(c + 2, 1'b1, 1'b1, "R4 on with ack");
    exp_at(c + 6, 1'b1, 1'b0, "R4 window ignores flag");
    exp_at(f - 1, 1'b1, 1'b0, "R4 last window cycle");
    exp_at(f, 1'b0, 1'b1, "R5 forced off");
    exp_at(f + 6, 1'b0, 1'b1, "R6 input ignored");
    exp_at(f + BLOCK - 1, 1'b0, 1'b1, "R5 block end");
    exp_at(f + BLOCK, 1'b1, 1'b0, "R6 released");
    exp_at(f + BLOCK + 2, 1'b1, 1'b0, "R6 follows input");
    wait_cyc(f);     desat_flag = 1'b0;
    wait_cyc(f + 2); drv_in = 1'b0;
    wait_cyc(f + 4); drv_in = 1'b1;
    drain();
    edge_to(1'b0, 1'b0, "R3 off after fault");

    // R7: series mode fault only reported.
    step(); series_mode = 1'b1;
    step(); c = cyc; drv_in = 1'b1; desat_flag = 1'b1;
    f = c + RESP + 3;
    exp_at(c + 2, 1'b1, 1'b1, "R7 on with ack");
    exp_at(c + 6, 1'b1, 1'b0, "R7 window");
    exp_at(f, 1'b1, 1'b1, "R7 reported, gate kept");
    exp_at(f + BLOCK - 1, 1'b1, 1'b1, "R7 report length");
    exp_at(f + BLOCK, 1'b1, 1'b0, "R7 report end");
    wait_cyc(f); desat_flag = 1'b0;
    drain();
    edge_to(1'b0, 1'b0, "R7 off");
    series_mode = 1'b0;

    // R8: supply low in normal mode.
    edge_to(1'b1, 1'b1, "R8 prep on");
    step(); c = cyc; supply_ok = 1'b0;
    exp_at(c + 1, 1'b0, 1'b1, "R8 normal gate off");
    exp_at(c + 3, 1'b0, 1'b1, "R8 normal held");
    exp_at(c + 4, 1'b1, 1'b0, "R8 normal recover");
    wait_cyc(c + 3); supply_ok = 1'b1;
    drain();

    // R8: supply low in series mode.
    series_mode = 1'b1;
    step(); c = cyc; supply_ok = 1'b0;
    exp_at(c + 1, 1'b1, 1'b1, "R8 series gate kept");
    exp_at(c + 3, 1'b1, 1'b1, "R8 series reported");
    exp_at(c + 4, 1'b1, 1'b0, "R8 series recover");
    wait_cyc(c + 3); supply_ok = 1'b1;
    drain();
    series_mode = 1'b0;
    edge_to(1'b0, 1'b0, "R8 off");

    // R1: pol_inv=0, low input requests on; polarity change gives no ack.
    step(); c = cyc; pol_inv = 1'b0;
    exp_at(c + 1, 1'b1, 1'b0, "R1 polarity flip, no ack");
    exp_at(c + 3, 1'b1, 1'b0, "R1 polarity flip, no ack");
    drain();
    edge_to(1'b1, 1'b0, "R1 high input means off");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule